// File: doc/BRIEF.md
# Life-Cycle Transition Sequencer

This block steps a device from one life-cycle state to another once a transition has been asked for. From idle it moves through a fixed chain of steps. It switches the clock source for one cycle. It asks a counter unit to increment and then to program. It samples a legality verdict, asks a hash unit to hash the unlock token, and optionally asks for a flash erase when the target is the RMA state. It then compares the hashed token against a reference value in two separate stages. Finally it asks for the new state to be programmed. Every check that fails, and every unit that returns an error, sends the machine to a terminal post-transition state.

Two independent escalation inputs take priority over the normal sequence and drive the machine into a terminal escalation state. The state register uses sparse codes. Any code outside the legal set is shown at once as an invalid state, and that state can only be left through escalation. A request from idle to scrap the device leads to its own terminal state. The counter, programming, hash and erase units sit outside the block and are reached through plain request/ack/error pins.

Top module: `lcx_trans_fsm`

## Requirements
- R1: While reset is asserted, `state_o` shows the reset code and every request output is low. On the first clock edge after reset is released the state becomes idle.
- R2: A request in idle runs the path idle, clock switch, counter increment, counter program, transition check, token hash. Clock switch lasts exactly one cycle. Each unit step holds its request high until its ack arrives.
- R3: The machine goes to post-transition, instead of the next step, when any of these happens: an ack with error from the counter increment, the counter program or the hash unit; a low legality input in transition check; or a token mismatch in either token-check stage.
- R4: The RMA target flag is latched when the request is accepted in idle. With the flag set, a good hash ack leads to the flash erase step, which waits for its ack and then goes to token check 0. With the flag clear, a good hash ack leads straight to token check 0.
- R5: When either escalation input is high, the next state is escalate, from every state except reset and scrap.
- R6: A scrap request in idle leads to the scrap state and wins over a simultaneous transition request. Scrap holds, and escalation inputs do not move it.
- R7: A state register value outside the fifteen legal codes shows on `state_o` as the invalid code in the same cycle. Invalid holds until an escalation input moves it to escalate.
- R8: Token check 1 always lasts one cycle. Moving on to the programming step needs both stored token copies to match the reference.
- R9: Post-transition holds while no escalation input is high. Escalate holds until reset.
- R10: `trans_ok_o` rises one edge after an ack without error in the programming step and stays high until reset. An ack with error leaves it low.
- R11: Each request output is high only during its own state: `clk_sw_o` in clock switch, `cnt_incr_req_o`, `cnt_prog_req_o`, `hash_req_o`, `rma_req_o` and `tprog_req_o` in their steps.
- R12: The `state_o` codes are: reset 2B1, idle 1D6, clock switch 0E3, counter increment 35A, counter program 14F, transition check 278, token hash 0B5, flash erase 3C2, token check 0 16D, token check 1 29E, program 07B, post-transition 3A9, scrap 1B4, escalate 2C7, invalid 05E (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trans_req_i | input | 1 | Start a transition (sampled in idle) |
| tgt_rma_i | input | 1 | Requested target is RMA (latched with the request) |
| scrap_req_i | input | 1 | Go to scrap (sampled in idle) |
| trans_legal_i | input | 1 | Legality verdict, sampled in transition check |
| esc0_i | input | 1 | Escalation input 0 |
| esc1_i | input | 1 | Escalation input 1 |
| clk_sw_o | output | 1 | Clock switch-over strobe |
| cnt_incr_req_o | output | 1 | Counter increment request |
| cnt_incr_ack_i | input | 1 | Counter increment done |
| cnt_incr_err_i | input | 1 | Counter increment error, valid with ack |
| cnt_prog_req_o | output | 1 | Counter program request |
| cnt_prog_ack_i | input | 1 | Counter program done |
| cnt_prog_err_i | input | 1 | Counter program error, valid with ack |
| hash_req_o | output | 1 | Token hash request |
| hash_ack_i | input | 1 | Hash done |
| hash_err_i | input | 1 | Hash error, valid with ack |
| hash_token_i | input | TOKEN_W | Hashed token, valid with ack |
| ref_token_i | input | TOKEN_W | Reference token for comparison |
| rma_req_o | output | 1 | Flash erase request |
| rma_ack_i | input | 1 | Flash erase done |
| tprog_req_o | output | 1 | New-state program request |
| tprog_ack_i | input | 1 | Program done |
| tprog_err_i | input | 1 | Program error, valid with ack |
| state_o | output | 10 | Decoded current state code |
| trans_ok_o | output | 1 | Transition committed |

## Verification
The state and every request output are Moore functions of the state register. An input seen in one cycle therefore shows its effect on `state_o` and the request pins right after the next rising edge. `trans_ok_o` is registered from the programming ack, so it also changes one edge after that ack. An illegal register value is the only case that shows on `state_o` within the same cycle, with no edge in between. The bench drives every input just after a falling edge and reads the outputs at the next falling edge. Each table row and each directed step thus covers exactly one rising edge, and the expected value is the state after that edge.

// File: rtl/lcx_pkg.sv
package lcx_pkg;

   localparam int STATE_W = 10;

   // Sparse codes, pairwise far apart; any other value is trapped as invalid.
   typedef enum logic [STATE_W-1:0] {
      ST_RESET      = 10'h2B1,
      ST_IDLE       = 10'h1D6,
      ST_CLK_MUX    = 10'h0E3,
      ST_CNT_INCR   = 10'h35A,
      ST_CNT_PROG   = 10'h14F,
      ST_TRANS_CHK  = 10'h278,
      ST_TOK_HASH   = 10'h0B5,
      ST_FLASH_RMA  = 10'h3C2,
      ST_TOK_CHK0   = 10'h16D,
      ST_TOK_CHK1   = 10'h29E,
      ST_TRANS_PROG = 10'h07B,
      ST_POST_TRANS = 10'h3A9,
      ST_SCRAP      = 10'h1B4,
      ST_ESCALATE   = 10'h2C7,
      ST_INVALID    = 10'h05E
   } lcx_st_e;

   function automatic lcx_st_e lcx_decode(input logic [STATE_W-1:0] raw);
      lcx_st_e s;
      case (raw)
         ST_RESET, ST_IDLE, ST_CLK_MUX, ST_CNT_INCR, ST_CNT_PROG,
         ST_TRANS_CHK, ST_TOK_HASH, ST_FLASH_RMA, ST_TOK_CHK0,
         ST_TOK_CHK1, ST_TRANS_PROG, ST_POST_TRANS, ST_SCRAP,
         ST_ESCALATE, ST_INVALID: s = lcx_st_e'(raw);
         default:                  s = ST_INVALID;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lcx_state_reg.sv
module lcx_state_reg
   import lcx_pkg::*;
(
   input  logic    clk_i,
   input  logic    rst_ni,
   input  lcx_st_e state_d_i,
   output lcx_st_e state_cur_o
);

   logic [STATE_W-1:0] state_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_RESET;
      else         state_q <= state_d_i;
   end

   // Illegal register contents are presented as the invalid state at once.
   assign state_cur_o = lcx_decode(state_q);

   AST_INVALID_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_cur_o == ST_INVALID |=> (state_cur_o == ST_INVALID || state_cur_o == ST_ESCALATE)); // R7

endmodule

// File: rtl/lcx_token_cmp.sv
module lcx_token_cmp #(
   parameter int TOKEN_W = 32,
   parameter int COPIES  = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cap_i,
   input  logic [TOKEN_W-1:0] tok_i,
   input  logic [TOKEN_W-1:0] ref_i,
   output logic [COPIES-1:0]  match_o
);

   if (COPIES < 1) begin : g_bad_copies
      $error("lcx_token_cmp: COPIES must be at least 1");
   end

   // Independent registers per comparison stage: a single upset cannot pass both.
   for (genvar i = 0; i < COPIES; i++) begin : g_copy
      logic [TOKEN_W-1:0] copy_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    copy_q <= '0;
         else if (cap_i) copy_q <= tok_i;
      end
      assign match_o[i] = (copy_q == ref_i);
   end

endmodule

// File: rtl/lcx_next_state.sv
module lcx_next_state
   import lcx_pkg::*;
(
   input  lcx_st_e    cur_i,
   input  logic       esc_i,
   input  logic       trans_req_i,
   input  logic       scrap_req_i,
   input  logic       legal_i,
   input  logic       incr_ack_i,
   input  logic       incr_err_i,
   input  logic       prog_ack_i,
   input  logic       prog_err_i,
   input  logic       hash_ack_i,
   input  logic       hash_err_i,
   input  logic       rma_sel_i,
   input  logic       rma_ack_i,
   input  logic [1:0] tok_match_i,
   input  logic       tprog_ack_i,
   output lcx_st_e    state_d_o
);

   always_comb begin
      state_d_o = cur_i;
      case (cur_i)
         ST_RESET:      state_d_o = ST_IDLE;
         ST_IDLE: begin
            if (scrap_req_i)      state_d_o = ST_SCRAP;
            else if (trans_req_i) state_d_o = ST_CLK_MUX;
         end
         ST_CLK_MUX:    state_d_o = ST_CNT_INCR;
         ST_CNT_INCR:   if (incr_ack_i) state_d_o = incr_err_i ? ST_POST_TRANS : ST_CNT_PROG;
         ST_CNT_PROG:   if (prog_ack_i) state_d_o = prog_err_i ? ST_POST_TRANS : ST_TRANS_CHK;
         ST_TRANS_CHK:  state_d_o = legal_i ? ST_TOK_HASH : ST_POST_TRANS;
         ST_TOK_HASH: begin
            if (hash_ack_i) begin
               if (hash_err_i)     state_d_o = ST_POST_TRANS;
               else if (rma_sel_i) state_d_o = ST_FLASH_RMA;
               else                state_d_o = ST_TOK_CHK0;
            end
         end
         ST_FLASH_RMA:  if (rma_ack_i) state_d_o = ST_TOK_CHK0;
         ST_TOK_CHK0:   state_d_o = tok_match_i[0] ? ST_TOK_CHK1 : ST_POST_TRANS;
         ST_TOK_CHK1:   state_d_o = tok_match_i[1] ? ST_TRANS_PROG : ST_POST_TRANS;
         ST_TRANS_PROG: if (tprog_ack_i) state_d_o = ST_POST_TRANS;
         ST_POST_TRANS, ST_SCRAP, ST_ESCALATE, ST_INVALID: state_d_o = cur_i;
         default:       state_d_o = ST_INVALID;
      endcase
      if (esc_i && cur_i != ST_RESET && cur_i != ST_SCRAP) state_d_o = ST_ESCALATE;
   end

endmodule

// File: rtl/lcx_trans_fsm.sv
module lcx_trans_fsm
   import lcx_pkg::*;
#(
   parameter int TOKEN_W = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               trans_req_i,
   input  logic               tgt_rma_i,
   input  logic               scrap_req_i,
   input  logic               trans_legal_i,
   input  logic               esc0_i,
   input  logic               esc1_i,
   output logic               clk_sw_o,
   output logic               cnt_incr_req_o,
   input  logic               cnt_incr_ack_i,
   input  logic               cnt_incr_err_i,
   output logic               cnt_prog_req_o,
   input  logic               cnt_prog_ack_i,
   input  logic               cnt_prog_err_i,
   output logic               hash_req_o,
   input  logic               hash_ack_i,
   input  logic               hash_err_i,
   input  logic [TOKEN_W-1:0] hash_token_i,
   input  logic [TOKEN_W-1:0] ref_token_i,
   output logic               rma_req_o,
   input  logic               rma_ack_i,
   output logic               tprog_req_o,
   input  logic               tprog_ack_i,
   input  logic               tprog_err_i,
   output logic [STATE_W-1:0] state_o,
   output logic               trans_ok_o
);

   localparam int CHECKS = 2;

   if (TOKEN_W < 8) begin : g_bad_token_w
      $error("lcx_trans_fsm: TOKEN_W must be at least 8");
   end

   lcx_st_e           cur_st, nxt_st;
   logic              esc_any, rma_q, tok_cap;
   logic [CHECKS-1:0] tok_match;

   assign esc_any = esc0_i | esc1_i;

   lcx_state_reg u_sreg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .state_d_i   (nxt_st),
      .state_cur_o (cur_st)
   );

   assign tok_cap = (cur_st == ST_TOK_HASH) && hash_ack_i && !hash_err_i;

   lcx_token_cmp #(.TOKEN_W(TOKEN_W), .COPIES(CHECKS)) u_tok (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cap_i   (tok_cap),
      .tok_i   (hash_token_i),
      .ref_i   (ref_token_i),
      .match_o (tok_match)
   );

   lcx_next_state u_nxt (
      .cur_i       (cur_st),
      .esc_i       (esc_any),
      .trans_req_i (trans_req_i),
      .scrap_req_i (scrap_req_i),
      .legal_i     (trans_legal_i),
      .incr_ack_i  (cnt_incr_ack_i),
      .incr_err_i  (cnt_incr_err_i),
      .prog_ack_i  (cnt_prog_ack_i),
      .prog_err_i  (cnt_prog_err_i),
      .hash_ack_i  (hash_ack_i),
      .hash_err_i  (hash_err_i),
      .rma_sel_i   (rma_q),
      .rma_ack_i   (rma_ack_i),
      .tok_match_i (tok_match),
      .tprog_ack_i (tprog_ack_i),
      .state_d_o   (nxt_st)
   );

   // Target and commit flags.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rma_q      <= 1'b0;
         trans_ok_o <= 1'b0;
      end else begin
         if (cur_st == ST_IDLE && trans_req_i) rma_q <= tgt_rma_i;
         if (cur_st == ST_TRANS_PROG && tprog_ack_i && !tprog_err_i) trans_ok_o <= 1'b1;
      end
   end

   assign clk_sw_o       = (cur_st == ST_CLK_MUX);
   assign cnt_incr_req_o = (cur_st == ST_CNT_INCR);
   assign cnt_prog_req_o = (cur_st == ST_CNT_PROG);
   assign hash_req_o     = (cur_st == ST_TOK_HASH);
   assign rma_req_o      = (cur_st == ST_FLASH_RMA);
   assign tprog_req_o    = (cur_st == ST_TRANS_PROG);
   assign state_o        = cur_st;

   AST_ESC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (esc_any && cur_st != ST_RESET && cur_st != ST_SCRAP) |=> cur_st == ST_ESCALATE); // R5
   AST_ESC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cur_st == ST_ESCALATE |=> cur_st == ST_ESCALATE); // R9
   AST_SCRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cur_st == ST_SCRAP |=> cur_st == ST_SCRAP); // R6
   AST_CHK1_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cur_st == ST_TOK_CHK1 |=> cur_st != ST_TOK_CHK1); // R8
   AST_CHK0_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur_st == ST_TOK_CHK0 && !tok_match[0] && !esc_any) |=> cur_st == ST_POST_TRANS); // R3
   AST_OK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trans_ok_o |=> trans_ok_o); // R10

endmodule

// File: tb/lcx_trans_fsm_tb.sv
module lcx_trans_fsm_tb;

   localparam int TW = 32;
   localparam logic [TW-1:0] KEY = 32'hC0DE_5A11;

   // State codes (R12)
   localparam logic [9:0] C_RESET = 10'h2B1, C_IDLE = 10'h1D6, C_CLKMUX = 10'h0E3,
      C_INCR = 10'h35A, C_PROG = 10'h14F, C_TCHK = 10'h278, C_HASH = 10'h0B5,
      C_RMA = 10'h3C2, C_CHK0 = 10'h16D, C_CHK1 = 10'h29E, C_TPROG = 10'h07B,
      C_POST = 10'h3A9, C_SCRAP = 10'h1B4, C_ESC = 10'h2C7, C_INV = 10'h05E;

   // Stimulus bits
   localparam logic [16:0] B_BAD = 17'h1 << 16, B_REQ = 17'h1 << 15, B_RMA = 17'h1 << 14,
      B_SCRAP = 17'h1 << 13, B_LEGAL = 17'h1 << 12, B_ESC0 = 17'h1 << 11, B_ESC1 = 17'h1 << 10,
      B_ATP = 17'h1 << 9, B_ARMA = 17'h1 << 8, B_AHASH = 17'h1 << 7, B_APROG = 17'h1 << 6,
      B_AINC = 17'h1 << 5, B_ETP = 17'h1 << 4, B_EHASH = 17'h1 << 2, B_EPROG = 17'h1 << 1,
      B_EINC = 17'h1;

   localparam int NROWS = 14;
   localparam logic [16:0] VEC [NROWS] = '{
      B_REQ | B_RMA, 17'h0, 17'h0, B_AINC, 17'h0, B_APROG, B_LEGAL,
      B_AHASH, 17'h0, B_ARMA, 17'h0, 17'h0, B_ATP, B_ESC1 };
   localparam logic [9:0] EXP [NROWS] = '{
      C_CLKMUX, C_INCR, C_INCR, C_PROG, C_PROG, C_TCHK, C_HASH,
      C_RMA, C_RMA, C_CHK0, C_CHK1, C_TPROG, C_POST, C_ESC };

   logic clk = 1'b0, rst_n = 1'b0;
   logic trans_req, tgt_rma, scrap_req, legal, esc0, esc1;
   logic incr_ack, incr_err, prog_ack, prog_err, hash_ack, hash_err, rma_ack, tp_ack, tp_err;
   logic [TW-1:0] hash_tok;
   logic clk_sw, incr_req, prog_req, hash_req, rma_req, tp_req, trans_ok;
   logic [9:0] state;
   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   lcx_trans_fsm #(.TOKEN_W(TW)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .trans_req_i(trans_req), .tgt_rma_i(tgt_rma),
      .scrap_req_i(scrap_req), .trans_legal_i(legal), .esc0_i(esc0), .esc1_i(esc1),
      .clk_sw_o(clk_sw), .cnt_incr_req_o(incr_req), .cnt_incr_ack_i(incr_ack),
      .cnt_incr_err_i(incr_err), .cnt_prog_req_o(prog_req), .cnt_prog_ack_i(prog_ack),
      .cnt_prog_err_i(prog_err), .hash_req_o(hash_req), .hash_ack_i(hash_ack),
      .hash_err_i(hash_err), .hash_token_i(hash_tok), .ref_token_i(KEY),
      .rma_req_o(rma_req), .rma_ack_i(rma_ack), .tprog_req_o(tp_req),
      .tprog_ack_i(tp_ack), .tprog_err_i(tp_err), .state_o(state), .trans_ok_o(trans_ok));

   task automatic drive(input logic [16:0] v);
      hash_tok  = v[16] ? (KEY ^ 32'h1) : KEY;
      trans_req = v[15]; tgt_rma = v[14]; scrap_req = v[13]; legal = v[12];
      esc0 = v[11]; esc1 = v[10]; tp_ack = v[9]; rma_ack = v[8]; hash_ack = v[7];
      prog_ack = v[6]; incr_ack = v[5]; tp_err = v[4]; hash_err = v[2];
      prog_err = v[1]; incr_err = v[0];
   endtask

   task automatic cyc();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] reqs();
      return {clk_sw, incr_req, prog_req, hash_req, rma_req, tp_req};
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; drive(17'h0);
      @(negedge clk); rst_n = 1'b1;
      cyc();
   endtask

   // From idle to the token-hash step.
   task automatic go_hash(input logic rma);
      drive(B_REQ | (rma ? B_RMA : 17'h0)); cyc();
      drive(17'h0); cyc();
      drive(B_AINC); cyc();
      drive(B_APROG); cyc();
      drive(B_LEGAL); cyc();
      drive(17'h0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      drive(17'h0);
      @(negedge clk); @(negedge clk);
      chk("R1 reset state", state, C_RESET);
      chk("R1 reset requests", reqs(), 6'b0);
      rst_n = 1'b1;
      cyc();
      chk("R1 idle after reset", state, C_IDLE);

      // Table: full RMA transition, commit, escalate from post-transition.
      for (int i = 0; i < NROWS; i++) begin
         drive(VEC[i]); cyc();
         chk($sformatf("R2/R4 row %0d", i), state, EXP[i]);
         if (i == 12) chk("R10 commit flag", trans_ok, 1'b1);
         if (i == 13) chk("R10 flag sticky", trans_ok, 1'b1);
      end
      drive(17'h0); cyc();
      chk("R9 escalate holds", state, C_ESC);

      // Non-RMA path, request strobes, program error.
      do_reset();
      drive(B_REQ); cyc();
      chk("R11 clock switch strobe", reqs(), 6'b100000);
      drive(17'h0); cyc();
      chk("R11 increment request", reqs(), 6'b010000);
      drive(B_AINC); cyc(); drive(B_APROG); cyc(); drive(B_LEGAL); cyc();
      chk("R11 hash request", reqs(), 6'b000100);
      drive(B_AHASH); cyc();
      chk("R4 skip erase", state, C_CHK0);
      drive(17'h0); cyc(); cyc();
      chk("R8 both copies pass", state, C_TPROG);
      drive(B_ATP | B_ETP); cyc();
      chk("R3 program error exit", state, C_POST);
      chk("R10 no commit on error", trans_ok, 1'b0);
      drive(17'h0); cyc();
      chk("R9 post holds", state, C_POST);

      // Increment error, then escalation input 0 from post.
      do_reset();
      drive(B_REQ); cyc(); drive(17'h0); cyc();
      drive(B_AINC | B_EINC); cyc();
      chk("R3 increment error", state, C_POST);
      drive(B_ESC0); cyc();
      chk("R5 esc0 from post", state, C_ESC);

      // Counter program error.
      do_reset();
      drive(B_REQ); cyc(); drive(17'h0); cyc(); drive(B_AINC); cyc();
      drive(B_APROG | B_EPROG); cyc();
      chk("R3 program-counter error", state, C_POST);

      // Illegal transition.
      do_reset();
      drive(B_REQ); cyc(); drive(17'h0); cyc(); drive(B_AINC); cyc(); drive(B_APROG); cyc();
      drive(17'h0); cyc();
      chk("R3 illegal transition", state, C_POST);

      // Hash error.
      do_reset(); go_hash(1'b1);
      drive(B_AHASH | B_EHASH); cyc();
      chk("R3 hash error", state, C_POST);

      // Token mismatch.
      do_reset(); go_hash(1'b0);
      drive(B_AHASH | B_BAD); cyc();
      chk("R4 check0 entry", state, C_CHK0);
      drive(17'h0); cyc();
      chk("R3 token mismatch", state, C_POST);

      // Escalation mid-sequence, hold until reset.
      do_reset();
      drive(B_REQ); cyc(); drive(17'h0); cyc(); drive(B_AINC); cyc();
      chk("R2 waits for ack", state, C_PROG);
      drive(B_ESC0); cyc();
      chk("R5 esc0 mid-sequence", state, C_ESC);
      drive(17'h0); cyc(); cyc();
      chk("R9 escalate holds", state, C_ESC);
      do_reset();
      chk("R9 reset leaves escalate", state, C_IDLE);

      // Scrap priority and immunity.
      drive(B_SCRAP | B_REQ); cyc();
      chk("R6 scrap wins", state, C_SCRAP);
      drive(B_ESC0 | B_ESC1); cyc();
      chk("R6 scrap ignores escalation", state, C_SCRAP);

      // Illegal encoding trap.
      do_reset();
      force u_dut.u_sreg.state_q = 10'h000;
      #0.5;
      chk("R7 invalid decode", state, C_INV);
      release u_dut.u_sreg.state_q;
      cyc();
      chk("R7 invalid holds", state, C_INV);
      drive(B_ESC1); cyc();
      chk("R7 invalid to escalate", state, C_ESC);

      finish_run();
   end

endmodule